// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block stands for the status side of a NOR-style flash while an internal byte program, sector erase or chip erase is running. A one-cycle start strobe brings in the operation kind, the target address, the byte to program, and the byte the cell holds now. The block then steps through its timed phases. Operations run as a series of internal pulses, each a fixed number of clock cycles long. A pulse counter stops the run at a limit. If the run reaches that limit without success, a failure is latched and is held until reset.

Reads are issued with a one-cycle strobe and a read address. When a read hits a busy operation, the block returns an 8-bit status word. That word carries a data-polling bit, a bit that flips on every read, a failure bit and a bit that shows whether the sector-add window is still open. When the block is idle, it returns the array data given on `arr_rdata`. The exceptions are the byte it has just programmed and the sectors it has just erased: for these it returns the completed result. All time windows are counted in clock cycles and set by parameters.

Top module: `fls_status_gen`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `rd_valid` are 0, and an idle read returns `arr_rdata` unchanged.
- R2: During a byte program (`op_kind` 2'b00), a status read returns bit 7 as the inverse of bit 7 of the byte being programmed. It returns bit 5 as 0 and bit 3 as 0.
- R3: A program with no 0-to-1 bit change stays busy for exactly PROG_PULSES×PULSE_CYC cycles. After that, a read of its address returns the programmed byte, and a read of any other address returns `arr_rdata`.
- R4: Bit 6 of the status word comes from a toggle register that is 0 after reset. The register inverts after every read that returns status.
- R5: During an erase, a status read returns bit 7 as 0. After the erase completes, a read of any erased sector returns 8'hFF.
- R6: A sector erase (`op_kind` 2'b01) keeps bit 3 at 0 for WIN_CYC cycles and then sets it to 1. A chip erase (`op_kind` 2'b10) shows bit 3 as 1 from the start.
- R7: A sector-erase start during the window adds its sector, which is then erased. A sector-erase start after the window closes is ignored.
- R8: During a sector erase, a read outside the selected sectors returns `arr_rdata` and leaves the toggle register unchanged. The sector is the top SECT_W bits of the address.
- R9: If a program tries to turn a 0 bit into 1 (a bit set in the new byte and clear in `cell_data`), the failure latches after MAX_PULSES pulses. Status then shows bit 5 as 1 and keeps bit 7 inverted, bit 6 keeps toggling, and `busy` stays 1.
- R10: Reset clears the failure, the pulse counter and the toggle register. Afterwards, reads return normal data.
- R11: A start strobe while an operation is busy is ignored, except for the sector-add case in R7.
- R12: `rd_valid` and `rd_data` are registered. They appear on the cycle after `rd_stb`, and `rd_valid` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start strobe for an operation |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 ignored |
| op_addr | input | ADDR_W | Target address of the operation |
| op_data | input | 8 | Byte to program |
| cell_data | input | 8 | Current contents of the target byte |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | 8 | Array data for the read address, valid with rd_stb |
| busy | output | 1 | An operation is in progress or has failed |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Status word or read data |

## Verification
Most internal faults show up on the very next read. A wrong phase or a stale target byte shows in bit 7 or bit 3 of that read. A lost or spurious toggle shows in bit 6 of the following status read. A faulty pulse or window counter shows at the ports a whole window later, as a wrong `busy` duration, a missing or extra erased sector, or a failure that never latches or that clears. The directed tests count the busy cycles exactly and compare every read byte with a value worked out from the requirements.

// File: rtl/fls_stat_pkg.sv
// Shared types for the flash status generator.
// Assumes: op_kind encodings are fixed by the port contract.
package fls_stat_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_SERASE = 2'b01,
        OP_CERASE = 2'b10,
        OP_RSVD   = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WINDOW = 2'b01,
        ST_PULSE  = 2'b10,
        ST_FAIL   = 2'b11
    } seq_state_e;

endpackage

// File: rtl/fls_op_seq.sv
// Operation sequencer: accepts starts, runs the sector-add window and the
// pulse train, counts pulses against the limit and latches failure.
// Assumes: cell_data is the current contents at op_addr when op_start is high.
module fls_op_seq
    import fls_stat_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int SECT_W       = 4,
    parameter int WIN_CYC      = 160,
    parameter int PULSE_CYC    = 16,
    parameter int PROG_PULSES  = 2,
    parameter int ERASE_PULSES = 8,
    parameter int MAX_PULSES   = 25
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_start,
    input  logic [1:0]             op_kind,
    input  logic [ADDR_W-1:0]      op_addr,
    input  logic [7:0]             op_data,
    input  logic [7:0]             cell_data,
    output seq_state_e             state_o,
    output logic                   is_erase_o,
    output logic [ADDR_W-1:0]      tgt_addr_o,
    output logic [7:0]             tgt_data_o,
    output logic [(1<<SECT_W)-1:0] sect_mask_o,
    output logic                   prog_res_o,
    output logic                   erase_res_o
);

    localparam int NUM_SECT = 1 << SECT_W;
    localparam int WIN_CW   = $clog2(WIN_CYC + 1);
    localparam int TICK_CW  = $clog2(PULSE_CYC + 1);
    localparam int MAXP_A   = (PROG_PULSES > ERASE_PULSES) ? PROG_PULSES : ERASE_PULSES;
    localparam int MAXP     = (MAXP_A > MAX_PULSES) ? MAXP_A : MAX_PULSES;
    localparam int PCNT_W   = $clog2(MAXP + 2);

    seq_state_e            state_q;
    logic                  is_erase_q;
    logic                  viol_q;
    logic [ADDR_W-1:0]     tgt_addr_q;
    logic [7:0]            tgt_data_q;
    logic [NUM_SECT-1:0]   mask_q;
    logic                  prog_res_q;
    logic                  erase_res_q;
    logic [WIN_CW-1:0]     win_q;
    logic [TICK_CW-1:0]    tick_q;
    logic [PCNT_W-1:0]     pcnt_q;

    logic [SECT_W-1:0]     start_sect;
    logic [PCNT_W-1:0]     pcnt_nxt;
    logic [PCNT_W-1:0]     need_pulses;
    logic                  pulse_end;
    logic                  win_end;

    // Decode the sector, the pulse target and the counter end points.
    always_comb begin
        start_sect  = op_addr[ADDR_W-1 -: SECT_W];
        pcnt_nxt    = pcnt_q + 1'b1;
        need_pulses = is_erase_q ? PCNT_W'(ERASE_PULSES) : PCNT_W'(PROG_PULSES);
        pulse_end   = (tick_q == TICK_CW'(PULSE_CYC - 1));
        win_end     = (win_q == WIN_CW'(WIN_CYC - 1));
    end

    // Main sequencer: start decode, window timing, pulse train, failure latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            is_erase_q  <= 1'b0;
            viol_q      <= 1'b0;
            tgt_addr_q  <= '0;
            tgt_data_q  <= '0;
            mask_q      <= '0;
            prog_res_q  <= 1'b0;
            erase_res_q <= 1'b0;
            win_q       <= '0;
            tick_q      <= '0;
            pcnt_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (op_start && op_kind != OP_RSVD) begin
                        prog_res_q  <= 1'b0;
                        erase_res_q <= 1'b0;
                        win_q       <= '0;
                        tick_q      <= '0;
                        pcnt_q      <= '0;
                        case (op_kind)
                            OP_PROG: begin
                                is_erase_q <= 1'b0;
                                tgt_addr_q <= op_addr;
                                tgt_data_q <= op_data;
                                viol_q     <= |(op_data & ~cell_data);
                                state_q    <= ST_PULSE;
                            end
                            OP_SERASE: begin
                                is_erase_q <= 1'b1;
                                viol_q     <= 1'b0;
                                mask_q     <= NUM_SECT'(1) << start_sect;
                                state_q    <= ST_WINDOW;
                            end
                            default: begin
                                is_erase_q <= 1'b1;
                                viol_q     <= 1'b0;
                                mask_q     <= '1;
                                state_q    <= ST_PULSE;
                            end
                        endcase
                    end
                end
                ST_WINDOW: begin
                    if (op_start && op_kind == OP_SERASE) begin
                        mask_q[start_sect] <= 1'b1;
                    end
                    if (win_end) begin
                        state_q <= ST_PULSE;
                    end else begin
                        win_q <= win_q + 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (pulse_end) begin
                        tick_q <= '0;
                        pcnt_q <= pcnt_nxt;
                        if (!viol_q && pcnt_nxt >= need_pulses) begin
                            state_q     <= ST_IDLE;
                            prog_res_q  <= !is_erase_q;
                            erase_res_q <= is_erase_q;
                        end else if (pcnt_nxt >= PCNT_W'(MAX_PULSES)) begin
                            state_q <= ST_FAIL;
                        end
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_FAIL;
                end
            endcase
        end
    end

    assign state_o     = state_q;
    assign is_erase_o  = is_erase_q;
    assign tgt_addr_o  = tgt_addr_q;
    assign tgt_data_o  = tgt_data_q;
    assign sect_mask_o = mask_q;
    assign prog_res_o  = prog_res_q;
    assign erase_res_o = erase_res_q;

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FAIL |=> state_q == ST_FAIL) else $error("failure released"); // R9
    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WINDOW |-> win_q < WIN_CW'(WIN_CYC)) else $error("window overrun"); // R6
    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= PCNT_W'(MAX_PULSES)) else $error("pulse count beyond limit"); // R9
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PULSE |=> (state_q != ST_PULSE || $stable(mask_q))) else $error("sector added late"); // R7

endmodule

// File: rtl/fls_stat_fmt.sv
// Read formatter: builds the status word for busy reads, returns completed
// results or array data on idle reads, and owns the read toggle register.
// Assumes: arr_rdata is valid for rd_addr in the cycle rd_stb is high.
module fls_stat_fmt
    import fls_stat_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SECT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_stb,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [7:0]             arr_rdata,
    input  seq_state_e             state_i,
    input  logic                   is_erase_i,
    input  logic [ADDR_W-1:0]      tgt_addr_i,
    input  logic [7:0]             tgt_data_i,
    input  logic [(1<<SECT_W)-1:0] sect_mask_i,
    input  logic                   prog_res_i,
    input  logic                   erase_res_i,
    output logic                   rd_valid,
    output logic [7:0]             rd_data
);

    logic       tgl_q;
    logic       busy;
    logic       in_sect;
    logic       stat_sel;
    logic [7:0] stat_word;
    logic [7:0] rd_nxt;

    // Select status, completed result or array data for this read.
    always_comb begin
        busy     = (state_i != ST_IDLE);
        in_sect  = sect_mask_i[rd_addr[ADDR_W-1 -: SECT_W]];
        stat_sel = busy && (!is_erase_i || in_sect);
        stat_word    = 8'h00;
        stat_word[7] = is_erase_i ? 1'b0 : ~tgt_data_i[7];
        stat_word[6] = tgl_q;
        stat_word[5] = (state_i == ST_FAIL);
        stat_word[3] = is_erase_i && (state_i != ST_WINDOW);
        if (stat_sel) begin
            rd_nxt = stat_word;
        end else if (!busy && prog_res_i && rd_addr == tgt_addr_i) begin
            rd_nxt = tgt_data_i;
        end else if (!busy && erase_res_i && in_sect) begin
            rd_nxt = 8'hFF;
        end else begin
            rd_nxt = arr_rdata;
        end
    end

    // Register the read result and flip the toggle on status reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q    <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) begin
                rd_data <= rd_nxt;
                if (stat_sel) begin
                    tgl_q <= ~tgl_q;
                end
            end
        end
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid) else $error("read result missing"); // R12
    AST_FAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && state_i == ST_FAIL) |=> rd_data[5]) else $error("failure bit low"); // R9
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && stat_sel && is_erase_i) |=> !rd_data[7]) else $error("erase poll bit high"); // R5
    AST_OUTSIDE_KEEP_TGL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && is_erase_i && !in_sect) |=> $stable(tgl_q)) else $error("toggle moved"); // R8

endmodule

// File: rtl/fls_status_gen.sv
// Top of the flash status generator: joins the operation sequencer and the
// read formatter. Assumes one start and one read strobe per cycle at most.
module fls_status_gen
    import fls_stat_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int SECT_W       = 4,
    parameter int WIN_CYC      = 160,
    parameter int PULSE_CYC    = 16,
    parameter int PROG_PULSES  = 2,
    parameter int ERASE_PULSES = 8,
    parameter int MAX_PULSES   = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [7:0]        cell_data,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);

    localparam int NUM_SECT = 1 << SECT_W;

    seq_state_e          state;
    logic                is_erase;
    logic [ADDR_W-1:0]   tgt_addr;
    logic [7:0]          tgt_data;
    logic [NUM_SECT-1:0] sect_mask;
    logic                prog_res;
    logic                erase_res;

    fls_op_seq #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .WIN_CYC(WIN_CYC),
        .PULSE_CYC(PULSE_CYC), .PROG_PULSES(PROG_PULSES),
        .ERASE_PULSES(ERASE_PULSES), .MAX_PULSES(MAX_PULSES)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .cell_data(cell_data),
        .state_o(state), .is_erase_o(is_erase), .tgt_addr_o(tgt_addr),
        .tgt_data_o(tgt_data), .sect_mask_o(sect_mask),
        .prog_res_o(prog_res), .erase_res_o(erase_res)
    );

    fls_stat_fmt #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) fmt_i (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .arr_rdata(arr_rdata), .state_i(state), .is_erase_i(is_erase),
        .tgt_addr_i(tgt_addr), .tgt_data_i(tgt_data), .sect_mask_i(sect_mask),
        .prog_res_i(prog_res), .erase_res_i(erase_res),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Busy covers every non-idle phase, the failed state included.
    assign busy = (state != ST_IDLE);

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_start && op_kind != 2'b11) |=> busy) else $error("start not taken"); // R11

endmodule

// File: tb/fls_status_gen_tb.sv
module fls_status_gen_tb_top;

    localparam int AW   = 8;
    localparam int SW   = 2;
    localparam int WIN  = 20;
    localparam int PCYC = 4;
    localparam int PPRG = 3;
    localparam int PERS = 5;
    localparam int PMAX = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0;
    logic [1:0]    op_kind = 2'b00;
    logic [AW-1:0] op_addr = '0;
    logic [7:0]    op_data = '0;
    logic [7:0]    cell_data = '0;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    arr_rdata = '0;
    logic          busy;
    logic          rd_valid;
    logic [7:0]    rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    fls_status_gen #(
        .ADDR_W(AW), .SECT_W(SW), .WIN_CYC(WIN), .PULSE_CYC(PCYC),
        .PROG_PULSES(PPRG), .ERASE_PULSES(PERS), .MAX_PULSES(PMAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .cell_data(cell_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_start = 1'b0;
        rd_stb = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic start_op(input logic [1:0] k, input logic [AW-1:0] a,
                            input logic [7:0] d, input logic [7:0] c);
        @(negedge clk);
        op_start = 1'b1; op_kind = k; op_addr = a; op_data = d; cell_data = c;
        @(posedge clk);
        #1;
        op_start = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [7:0] ar,
                           output logic [7:0] d, output logic v);
        @(negedge clk);
        rd_stb = 1'b1; rd_addr = a; arr_rdata = ar;
        @(posedge clk);
        #1;
        v = rd_valid;
        d = rd_data;
        rd_stb = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic v;
        do_reset();
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        do_read(8'h05, 8'h3C, d, v);
        check(v == 1'b1, "R12 rd_valid after strobe", v, 1);
        check(d == 8'h3C, "R1 idle read", d, 8'h3C);
        @(posedge clk); #1;
        check(rd_valid == 1'b0, "R12 rd_valid one cycle", rd_valid, 0);
    endtask

    task automatic t_prog_timing();
        logic [7:0] d; logic v; int cnt;
        do_reset();
        start_op(2'b00, 8'h12, 8'hA5, 8'hFF);
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            @(posedge clk); #1;
        end
        check(cnt == PPRG * PCYC, "R3 program busy cycles", cnt, PPRG * PCYC);
        do_read(8'h12, 8'h00, d, v);
        check(d == 8'hA5, "R3 programmed byte", d, 8'hA5);
        do_read(8'h13, 8'h11, d, v);
        check(d == 8'h11, "R3 other address", d, 8'h11);
    endtask

    task automatic t_prog_poll();
        logic [7:0] d; logic v;
        do_reset();
        start_op(2'b00, 8'h12, 8'h5A, 8'hFF);
        do_read(8'h12, 8'h00, d, v);
        check(d[7] == 1'b1, "R2 complement bit7", d[7], 1);
        check(d[5] == 1'b0 && d[3] == 1'b0, "R2 bits 5 and 3 low", {d[5], d[3]}, 0);
        check(d[6] == 1'b0, "R4 first toggle value", d[6], 0);
        do_read(8'h12, 8'h00, d, v);
        check(d[6] == 1'b1, "R4 toggle flips", d[6], 1);
        start_op(2'b00, 8'h20, 8'h00, 8'hFF);
        wait_idle();
        do_read(8'h12, 8'h00, d, v);
        check(d == 8'h5A, "R3 true data after done", d, 8'h5A);
        do_read(8'h20, 8'h77, d, v);
        check(d == 8'h77, "R11 start while busy ignored", d, 8'h77);
    endtask

    task automatic t_serase();
        logic [7:0] d; logic v;
        do_reset();
        start_op(2'b01, 8'h40, 8'h00, 8'h00);
        do_read(8'h41, 8'h00, d, v);
        check(d[7] == 1'b0, "R5 erase poll bit7", d[7], 0);
        check(d[3] == 1'b0, "R6 window bit3 low", d[3], 0);
        check(d[6] == 1'b0, "R4 toggle first erase read", d[6], 0);
        do_read(8'hC0, 8'h3E, d, v);
        check(d == 8'h3E, "R8 outside sector read", d, 8'h3E);
        start_op(2'b01, 8'h80, 8'h00, 8'h00);
        repeat (WIN + 2) @(posedge clk);
        do_read(8'h41, 8'h00, d, v);
        check(d[3] == 1'b1, "R6 bit3 after window", d[3], 1);
        check(d[6] == 1'b1, "R8 toggle kept by outside read", d[6], 1);
        check(busy == 1'b1, "R6 still erasing", busy, 1);
        start_op(2'b01, 8'hC5, 8'h00, 8'h00);
        wait_idle();
        do_read(8'h41, 8'h00, d, v);
        check(d == 8'hFF, "R5 erased sector", d, 8'hFF);
        do_read(8'h85, 8'h00, d, v);
        check(d == 8'hFF, "R7 added sector erased", d, 8'hFF);
        do_read(8'hC5, 8'h12, d, v);
        check(d == 8'h12, "R7 late sector ignored", d, 8'h12);
    endtask

    task automatic t_cerase();
        logic [7:0] d; logic v;
        do_reset();
        start_op(2'b10, 8'h00, 8'h00, 8'h00);
        do_read(8'h03, 8'h00, d, v);
        check(d[3] == 1'b1 && d[7] == 1'b0, "R6 chip erase bit3 high bit7 low", d, 8'h08);
        wait_idle();
        do_read(8'hC0, 8'h00, d, v);
        check(d == 8'hFF, "R5 chip erase result", d, 8'hFF);
    endtask

    task automatic t_fail();
        logic [7:0] d; logic v; logic b;
        do_reset();
        start_op(2'b00, 8'h10, 8'hF0, 8'h70);
        do_read(8'h10, 8'h00, d, v);
        check(d[5] == 1'b0, "R9 no failure before limit", d[5], 0);
        repeat (PMAX * PCYC + 10) @(posedge clk);
        #1;
        check(busy == 1'b1, "R9 busy after failure", busy, 1);
        do_read(8'h10, 8'h00, d, v);
        check(d[5] == 1'b1, "R9 failure bit", d[5], 1);
        check(d[7] == 1'b0, "R9 bit7 stays complemented", d[7], 0);
        b = d[6];
        do_read(8'h10, 8'h00, d, v);
        check(d[6] == ~b, "R9 toggle continues", d[6], ~b);
        repeat (30) @(posedge clk);
        #1;
        check(busy == 1'b1, "R9 failure held", busy, 1);
        do_reset();
        check(busy == 1'b0, "R10 reset clears failure", busy, 0);
        do_read(8'h10, 8'h70, d, v);
        check(d == 8'h70, "R10 normal read after reset", d, 8'h70);
        start_op(2'b00, 8'h10, 8'h00, 8'h70);
        do_read(8'h10, 8'h00, d, v);
        check(d[6] == 1'b0 && d[5] == 1'b0, "R10 toggle and flag cleared", d, 8'h80);
        wait_idle();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_prog_timing();
        t_prog_poll();
        t_serase();
        t_cerase();
        t_fail();
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

endmodule